// File: doc/BRIEF.md
# DMA Register Front End with Page Extension

This block sits between an 8-bit CPU I/O port and a four-channel DMA sequencer. It decodes the CPU's register offsets and holds each channel's programmed start address and transfer count. It also holds the mask, mode, request and command settings. It returns the sequencer's live address and remaining count when the CPU reads them back. Each 16-bit value travels through one byte-wide port as two accesses, low byte first. An internal byte pointer decides which half an access touches.

Each channel also has an 8-bit page latch outside the sequencer. For the channel the sequencer reports as active, the block places that channel's page above the sequencer's 16-bit current address. This gives a 24-bit bus address. The page never takes part in address counting, so a transfer that runs past the top of a 64K block wraps inside that block.

Top module: `dma_regfront`

## Requirements
- R1: After reset, all four mask bits are 1, and the byte pointer points at the low byte. The command byte, the software request bits, the terminal-count flags and every page latch are 0.
- R2: Channel n's address port is at offset 4n and its count port at offset 4n+2. Two writes load the low byte and then the high byte of that channel's base value. The channel's reload strobe (address or count) is high for exactly the one cycle after the high-byte write.
- R3: A read of an address or count port returns a byte of the sequencer's current address or remaining count: the low byte when the pointer is low, the high byte otherwise. Every read or write of one of these ports toggles the pointer.
- R4: A write to offset 0x18 clears the byte pointer, so the next address or count access uses the low byte.
- R5: Three mask commands exist. A write to 0x14 sets the mask bit of channel wdata[1:0] to wdata[2]. A write to 0x1C clears all mask bits. A write to 0x1E loads all mask bits from wdata[3:0].
- R6: A write to 0x16 stores wdata[7:2] as the 6-bit mode of channel wdata[1:0]. A write to 0x12 sets the software request bit of channel wdata[1:0] to wdata[2]. A write to 0x10 loads the command byte.
- R7: A read of 0x10 returns the sequencer's request lines in bits [7:4] and the sticky terminal-count flags in bits [3:0]. The read clears the flags, except that a terminal-count pulse arriving in the same cycle leaves its flag set.
- R8: A write to 0x1A clears the byte pointer, the terminal-count flags, the software requests and the command byte, and it sets all mask bits. A read of 0x1A returns the sequencer's temporary byte and leaves the pointer unchanged.
- R9: The page latches of channels 0, 1, 2 and 3 are at I/O addresses 0x87, 0x83, 0x81 and 0x82, and each can be written and read back.
- R10: bus_addr equals the active channel's page latch in bits [23:16] and that channel's current address in bits [15:0]. When the low 16 bits roll over from 0xFFFF to 0x0000, the page stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_addr | input | 8 | CPU I/O address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, valid while cpu_rd is high |
| seq_cur_addr | input | 64 | Current address of each channel, 16 bits per channel |
| seq_cur_cnt | input | 64 | Remaining count of each channel, 16 bits per channel |
| seq_tc | input | 4 | Terminal-count pulse per channel |
| seq_drq | input | 4 | Request line per channel |
| seq_temp | input | 8 | Sequencer temporary byte |
| act_ch | input | 2 | Index of the channel that owns the bus |
| cfg_base_addr | output | 64 | Programmed base address per channel |
| cfg_base_cnt | output | 64 | Programmed base count per channel |
| cfg_ld_addr | output | 4 | Address reload strobe per channel |
| cfg_ld_cnt | output | 4 | Count reload strobe per channel |
| cfg_mask | output | 4 | Mask bit per channel |
| cfg_mode | output | 24 | 6-bit mode per channel |
| cfg_cmd | output | 8 | Command byte |
| cfg_swreq | output | 4 | Software request bit per channel |
| bus_addr | output | 24 | Page-extended bus address |

## Verification
The bench drives the byte pointer through several access patterns. One is pairs of writes followed by pairs of reads. Another mixes a write and a read on different ports, which shows that reads toggle the pointer too. A third is a pointer left high and then cleared by the clear command or by master clear; each case shows whether the pointer state stays correct. The status port is read with a terminal-count pulse before the read and with one during the read, which separates clear-on-read from a pulse that arrives in the same cycle. Moving the active channel's address across 0xFFFF separates a page held in its latch from a page that takes a carry.

// File: rtl/dma_regfront_pkg.sv
package dma_regfront_pkg;
    localparam int NCH    = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int WORD_W = 16;
    localparam int PAGE_W = 8;
    localparam int MODE_W = 6;
    localparam int BUS_W  = PAGE_W + WORD_W;

    localparam logic [4:0] OFF_CMD   = 5'h10;
    localparam logic [4:0] OFF_REQ   = 5'h12;
    localparam logic [4:0] OFF_SMASK = 5'h14;
    localparam logic [4:0] OFF_MODE  = 5'h16;
    localparam logic [4:0] OFF_CLRFF = 5'h18;
    localparam logic [4:0] OFF_MCLR  = 5'h1A;
    localparam logic [4:0] OFF_CLRM  = 5'h1C;
    localparam logic [4:0] OFF_ALLM  = 5'h1E;

    // I/O address of each channel's page latch
    function automatic logic [7:0] page_port(input int ch);
        case (ch)
            0:       return 8'h87;
            1:       return 8'h83;
            2:       return 8'h81;
            default: return 8'h82;
        endcase
    endfunction
endpackage

// File: rtl/dma_page_bank.sv
module dma_page_bank
    import dma_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    input  logic [CH_W-1:0]   act_ch,
    input  logic [WORD_W-1:0] act_addr,
    output logic              hit,
    output logic [7:0]        rdata,
    output logic [BUS_W-1:0]  bus_addr
);
    typedef struct packed {
        logic [NCH-1:0][PAGE_W-1:0] page;
    } page_st_t;

    page_st_t       s_d, s_q;
    logic [NCH-1:0] hit_vec;

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign hit_vec[g] = (addr == page_port(g));
    end

    always_comb begin
        s_d   = s_q;
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit_vec[i]) begin
                rdata = s_q.page[i];
                if (wr) s_d.page[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit      = |hit_vec;
    assign bus_addr = {s_q.page[act_ch], act_addr};
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_regfront_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  logic                    wr,
    input  logic                    rd,
    input  logic [4:0]              off,
    input  logic [7:0]              wdata,
    input  logic [NCH*WORD_W-1:0]   cur_addr_i,
    input  logic [NCH*WORD_W-1:0]   cur_cnt_i,
    input  logic [NCH-1:0]          tc_i,
    input  logic [NCH-1:0]          drq_i,
    input  logic [7:0]              temp_i,
    output logic [7:0]              rdata_o,
    output logic [NCH*WORD_W-1:0]   base_addr_o,
    output logic [NCH*WORD_W-1:0]   base_cnt_o,
    output logic [NCH-1:0]          ld_addr_o,
    output logic [NCH-1:0]          ld_cnt_o,
    output logic [NCH-1:0]          mask_o,
    output logic [NCH*MODE_W-1:0]   mode_o,
    output logic [7:0]              cmd_o,
    output logic [NCH-1:0]          swreq_o
);
    typedef struct packed {
        logic                          ff;
        logic [NCH-1:0][WORD_W-1:0]    base_addr;
        logic [NCH-1:0][WORD_W-1:0]    base_cnt;
        logic [NCH-1:0][MODE_W-1:0]    mode;
        logic [NCH-1:0]                mask;
        logic [NCH-1:0]                tc;
        logic [NCH-1:0]                swreq;
        logic [NCH-1:0]                ld_a;
        logic [NCH-1:0]                ld_c;
        logic [7:0]                    cmd;
    } ctrl_st_t;

    ctrl_st_t         s_d, s_q;
    logic             is_chan, is_cnt;
    logic [CH_W-1:0]  ch, wch;
    logic [WORD_W-1:0] cur_val;

    assign is_chan = ~off[4];
    assign is_cnt  = off[1];
    assign ch      = off[CH_W+1:2];
    assign wch     = wdata[CH_W-1:0];
    assign cur_val = is_cnt ? cur_cnt_i[ch*WORD_W +: WORD_W]
                            : cur_addr_i[ch*WORD_W +: WORD_W];

    always_comb begin
        s_d      = s_q;
        s_d.ld_a = '0;
        s_d.ld_c = '0;
        s_d.tc   = s_q.tc | tc_i;

        if (sel && is_chan && (wr || rd)) s_d.ff = ~s_q.ff;

        if (sel && wr) begin
            if (is_chan) begin
                if (!is_cnt) begin
                    if (!s_q.ff) s_d.base_addr[ch][7:0] = wdata;
                    else begin
                        s_d.base_addr[ch][WORD_W-1:8] = wdata;
                        s_d.ld_a[ch] = 1'b1;
                    end
                end else begin
                    if (!s_q.ff) s_d.base_cnt[ch][7:0] = wdata;
                    else begin
                        s_d.base_cnt[ch][WORD_W-1:8] = wdata;
                        s_d.ld_c[ch] = 1'b1;
                    end
                end
            end else begin
                case (off)
                    OFF_CMD:   s_d.cmd = wdata;
                    OFF_REQ:   s_d.swreq[wch] = wdata[2];
                    OFF_SMASK: s_d.mask[wch] = wdata[2];
                    OFF_MODE:  s_d.mode[wch] = wdata[7:2];
                    OFF_CLRFF: s_d.ff = 1'b0;
                    OFF_MCLR: begin
                        s_d.ff    = 1'b0;
                        s_d.mask  = '1;
                        s_d.tc    = '0;
                        s_d.swreq = '0;
                        s_d.cmd   = '0;
                    end
                    OFF_CLRM:  s_d.mask = '0;
                    OFF_ALLM:  s_d.mask = wdata[NCH-1:0];
                    default:   ;
                endcase
            end
        end

        if (sel && rd && off == OFF_CMD) s_d.tc = tc_i;
    end

    always_comb begin
        rdata_o = '0;
        if (sel) begin
            if (is_chan)              rdata_o = s_q.ff ? cur_val[WORD_W-1:8] : cur_val[7:0];
            else if (off == OFF_CMD)  rdata_o = {drq_i, s_q.tc};
            else if (off == OFF_MCLR) rdata_o = temp_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign base_addr_o = s_q.base_addr;
    assign base_cnt_o  = s_q.base_cnt;
    assign ld_addr_o   = s_q.ld_a;
    assign ld_cnt_o    = s_q.ld_c;
    assign mask_o      = s_q.mask;
    assign mode_o      = s_q.mode;
    assign cmd_o       = s_q.cmd;
    assign swreq_o     = s_q.swreq;
endmodule

// File: rtl/dma_regfront.sv
module dma_regfront
    import dma_regfront_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_wr,
    input  logic                  cpu_rd,
    input  logic [7:0]            cpu_addr,
    input  logic [7:0]            cpu_wdata,
    output logic [7:0]            cpu_rdata,
    input  logic [NCH*WORD_W-1:0] seq_cur_addr,
    input  logic [NCH*WORD_W-1:0] seq_cur_cnt,
    input  logic [NCH-1:0]        seq_tc,
    input  logic [NCH-1:0]        seq_drq,
    input  logic [7:0]            seq_temp,
    input  logic [CH_W-1:0]       act_ch,
    output logic [NCH*WORD_W-1:0] cfg_base_addr,
    output logic [NCH*WORD_W-1:0] cfg_base_cnt,
    output logic [NCH-1:0]        cfg_ld_addr,
    output logic [NCH-1:0]        cfg_ld_cnt,
    output logic [NCH-1:0]        cfg_mask,
    output logic [NCH*MODE_W-1:0] cfg_mode,
    output logic [7:0]            cfg_cmd,
    output logic [NCH-1:0]        cfg_swreq,
    output logic [BUS_W-1:0]      bus_addr
);
    logic       sel_ctrl, pg_hit;
    logic [7:0] ctrl_rdata, pg_rdata;

    // controller window: 0x00..0x1F, even offsets only
    assign sel_ctrl = (cpu_addr[7:5] == 3'b000) && !cpu_addr[0];

    dma_ctrl_regs u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel_ctrl),
        .wr          (cpu_wr),
        .rd          (cpu_rd),
        .off         (cpu_addr[4:0]),
        .wdata       (cpu_wdata),
        .cur_addr_i  (seq_cur_addr),
        .cur_cnt_i   (seq_cur_cnt),
        .tc_i        (seq_tc),
        .drq_i       (seq_drq),
        .temp_i      (seq_temp),
        .rdata_o     (ctrl_rdata),
        .base_addr_o (cfg_base_addr),
        .base_cnt_o  (cfg_base_cnt),
        .ld_addr_o   (cfg_ld_addr),
        .ld_cnt_o    (cfg_ld_cnt),
        .mask_o      (cfg_mask),
        .mode_o      (cfg_mode),
        .cmd_o       (cfg_cmd),
        .swreq_o     (cfg_swreq)
    );

    dma_page_bank u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cpu_wr),
        .addr     (cpu_addr),
        .wdata    (cpu_wdata),
        .act_ch   (act_ch),
        .act_addr (seq_cur_addr[act_ch*WORD_W +: WORD_W]),
        .hit      (pg_hit),
        .rdata    (pg_rdata),
        .bus_addr (bus_addr)
    );

    assign cpu_rdata = sel_ctrl ? ctrl_rdata : (pg_hit ? pg_rdata : 8'h00);
endmodule

// File: rtl/dma_regfront_chk.sv
module dma_regfront_chk
    import dma_regfront_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cpu_wr,
    input logic                  cpu_rd,
    input logic [7:0]            cpu_addr,
    input logic [7:0]            cpu_rdata,
    input logic [NCH-1:0]        seq_tc,
    input logic [CH_W-1:0]       act_ch,
    input logic [BUS_W-1:0]      bus_addr,
    input logic [NCH-1:0]        cfg_mask,
    input logic [NCH-1:0]        cfg_swreq,
    input logic [NCH-1:0]        cfg_ld_addr,
    input logic [NCH-1:0]        cfg_ld_cnt
);
    assert_ld_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_ld_addr) && $onehot0(cfg_ld_cnt));

    assert_clr_all_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 8'h1C) |=> (cfg_mask == '0));

    assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == 8'h10 && seq_tc == '0) ##1 (cpu_rd && cpu_addr == 8'h10)
        |-> (cpu_rdata[NCH-1:0] == '0));

    assert_mclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 8'h1A) |=> (cfg_mask == '1 && cfg_swreq == '0));

    assert_page_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cpu_wr) && $stable(act_ch)) |-> $stable(bus_addr[BUS_W-1:WORD_W]));
endmodule

bind dma_regfront dma_regfront_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_wr      (cpu_wr),
    .cpu_rd      (cpu_rd),
    .cpu_addr    (cpu_addr),
    .cpu_rdata   (cpu_rdata),
    .seq_tc      (seq_tc),
    .act_ch      (act_ch),
    .bus_addr    (bus_addr),
    .cfg_mask    (cfg_mask),
    .cfg_swreq   (cfg_swreq),
    .cfg_ld_addr (cfg_ld_addr),
    .cfg_ld_cnt  (cfg_ld_cnt)
);

// File: tb/dma_regfront_tb.sv
module dma_regfront_tb;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cpu_wr = 0, cpu_rd = 0;
    logic [7:0]  cpu_addr = 0, cpu_wdata = 0;
    logic [7:0]  cpu_rdata;
    logic [63:0] seq_cur_addr = 0, seq_cur_cnt = 0;
    logic [3:0]  seq_tc = 0, seq_drq = 0;
    logic [7:0]  seq_temp = 0;
    logic [1:0]  act_ch = 0;
    logic [63:0] cfg_base_addr, cfg_base_cnt;
    logic [3:0]  cfg_ld_addr, cfg_ld_cnt, cfg_mask, cfg_swreq;
    logic [23:0] cfg_mode;
    logic [7:0]  cfg_cmd;
    logic [23:0] bus_addr;

    int checks = 0, failures = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t rq[$];

    always #(CLK_P/2) clk = ~clk;

    dma_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .seq_cur_addr(seq_cur_addr), .seq_cur_cnt(seq_cur_cnt),
        .seq_tc(seq_tc), .seq_drq(seq_drq), .seq_temp(seq_temp), .act_ch(act_ch),
        .cfg_base_addr(cfg_base_addr), .cfg_base_cnt(cfg_base_cnt),
        .cfg_ld_addr(cfg_ld_addr), .cfg_ld_cnt(cfg_ld_cnt), .cfg_mask(cfg_mask),
        .cfg_mode(cfg_mode), .cfg_cmd(cfg_cmd), .cfg_swreq(cfg_swreq),
        .bus_addr(bus_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // inputs change one time unit after a rising edge
    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #1;
        cpu_wr = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp; it.tag = tag;
        rq.push_back(it);
        cpu_rd = 1; cpu_addr = a;
        @(posedge clk); #1;
        cpu_rd = 0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    // monitor: compares each read mid-cycle
    always @(negedge clk) begin
        if (cpu_rd) begin
            if (rq.size() == 0) begin
                checks++; failures++;
                $display("FAIL monitor read with no expectation actual=%0h expected=none", cpu_rdata);
            end else begin
                rd_item_t it;
                it = rq.pop_front();
                check(it.tag, {24'h0, cpu_rdata}, {24'h0, it.exp});
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        idle();

        // R1 reset state
        check("R1 mask", cfg_mask, 4'hF);
        check("R1 cmd", cfg_cmd, 8'h00);
        check("R1 swreq", cfg_swreq, 4'h0);
        check("R1 bus_addr", bus_addr, 24'h0);
        bus_rd(8'h87, 8'h00, "R1 page0");
        bus_rd(8'h10, 8'h00, "R1 status");

        // R2 base loads
        bus_wr(8'h08, 8'h56);
        check("R2 no early load", cfg_ld_addr, 4'h0);
        bus_wr(8'h08, 8'h34);
        check("R2 base addr ch2", cfg_base_addr[32 +: 16], 16'h3456);
        check("R2 ld addr pulse", cfg_ld_addr, 4'b0100);
        idle();
        check("R2 ld addr one cycle", cfg_ld_addr, 4'h0);
        bus_wr(8'h06, 8'hFF);
        bus_wr(8'h06, 8'h01);
        check("R2 base cnt ch1", cfg_base_cnt[16 +: 16], 16'h01FF);
        check("R2 ld cnt pulse", cfg_ld_cnt, 4'b0010);

        // R3 readback of current values
        seq_cur_addr[48 +: 16] = 16'hBEEF;
        seq_cur_cnt[0 +: 16]   = 16'h1234;
        seq_cur_addr[0 +: 16]  = 16'hA5C3;
        seq_cur_addr[16 +: 16] = 16'h7788;
        bus_rd(8'h0C, 8'hEF, "R3 addr ch3 low");
        bus_rd(8'h0C, 8'hBE, "R3 addr ch3 high");
        bus_rd(8'h02, 8'h34, "R3 cnt ch0 low");
        bus_rd(8'h02, 8'h12, "R3 cnt ch0 high");
        bus_wr(8'h00, 8'h11);
        bus_rd(8'h00, 8'hA5, "R3 read after write is high");

        // R4 pointer clear
        bus_rd(8'h04, 8'h88, "R4 ch1 low");
        bus_wr(8'h18, 8'h00);
        bus_rd(8'h04, 8'h88, "R4 low again after clear");
        bus_rd(8'h04, 8'h77, "R4 then high");

        // R5 masks
        bus_wr(8'h1C, 8'h00);
        check("R5 clear all", cfg_mask, 4'h0);
        bus_wr(8'h14, 8'h05);
        check("R5 single set ch1", cfg_mask, 4'b0010);
        bus_wr(8'h14, 8'h01);
        check("R5 single clear ch1", cfg_mask, 4'b0000);
        bus_wr(8'h1E, 8'hA9);
        check("R5 write all", cfg_mask, 4'b1001);

        // R6 mode, request, command
        bus_wr(8'h16, 8'hB6);
        check("R6 mode ch2", cfg_mode[12 +: 6], 6'b101101);
        check("R6 mode ch0 untouched", cfg_mode[0 +: 6], 6'b000000);
        bus_wr(8'h12, 8'h07);
        check("R6 swreq ch3", cfg_swreq, 4'b1000);
        bus_wr(8'h10, 8'h5A);
        check("R6 cmd", cfg_cmd, 8'h5A);

        // R7 status
        seq_drq = 4'b0011;
        seq_tc = 4'b0101; idle(); seq_tc = 4'b0000;
        bus_rd(8'h10, 8'h35, "R7 status flags");
        bus_rd(8'h10, 8'h30, "R7 cleared by read");
        seq_tc = 4'b1000;
        bus_rd(8'h10, 8'h30, "R7 read with pulse");
        seq_tc = 4'b0000;
        bus_rd(8'h10, 8'h38, "R7 same-cycle pulse kept");

        // R8 master clear
        seq_tc = 4'b0001; idle(); seq_tc = 4'b0000;
        bus_rd(8'h00, 8'hC3, "R8 set pointer high");
        bus_wr(8'h1A, 8'h00);
        check("R8 mask set", cfg_mask, 4'hF);
        check("R8 swreq clear", cfg_swreq, 4'h0);
        check("R8 cmd clear", cfg_cmd, 8'h00);
        seq_temp = 8'h6C;
        bus_rd(8'h1A, 8'h6C, "R8 temp read");
        bus_rd(8'h00, 8'hC3, "R8 pointer low after clear");
        bus_rd(8'h00, 8'hA5, "R8 then high");
        bus_rd(8'h10, 8'h30, "R8 tc flags cleared");

        // R9 page latches
        bus_wr(8'h87, 8'h11);
        bus_wr(8'h83, 8'h22);
        bus_wr(8'h81, 8'h33);
        bus_wr(8'h82, 8'h44);
        bus_rd(8'h87, 8'h11, "R9 page ch0");
        bus_rd(8'h83, 8'h22, "R9 page ch1");
        bus_rd(8'h81, 8'h33, "R9 page ch2");
        bus_rd(8'h82, 8'h44, "R9 page ch3");

        // R10 bus address and wrap
        act_ch = 2'd2;
        seq_cur_addr[32 +: 16] = 16'hFFFF;
        idle();
        check("R10 bus at top", bus_addr, 24'h33FFFF);
        seq_cur_addr[32 +: 16] = 16'h0000;
        idle();
        check("R10 wrap keeps page", bus_addr, 24'h330000);
        act_ch = 2'd0;
        idle();
        check("R10 ch0 bus", bus_addr, 24'h11A5C3);

        idle();
        if (rq.size() != 0) begin
            checks++; failures++;
            $display("FAIL monitor pending reads actual=%0d expected=0", rq.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule